// File: doc/BRIEF.md
# Manual Reset Button Qualifier

This block turns a raw, active-low reset button level into a clean "press active" level for a downstream reset sequencer. The button line idles high, may bounce when it moves and may carry short glitches. The block brings the level into the clock domain through a flop chain. It then looks at the level only on cycles that carry a one-millisecond tick enable, and judges it by counting runs of equal samples.

A press is accepted only after a run of consecutive low samples long enough to reject pulses under one millisecond. The run is also short enough that any press of twenty milliseconds or more is always taken. Once the press is accepted, the output stays high while the button is held. It drops when the button has been seen high on enough consecutive samples, so that the sequencer's reset stretch starts at the release. Bounce at release does not end the press early.

Top module: `mrst_qualifier`

## Requirements
- R1: During and right after reset, `press_active` is 0 and the block treats the button as released.
- R2: The raw level passes through `SYNC_STAGES` (default 2) flops. A level driven before a rising edge is used by a tick only from the third rising edge on; a tick on the second edge still uses the previous level.
- R3: The button level matters only on cycles where `tick_1ms` is 1. Any change between ticks that is gone again before the next tick has no effect.
- R4: `press_active` rises at the clock edge of the `PRESS_SAMPLES`-th (default 10) consecutive tick at which the synchronised level is low (0).
- R5: A high sample before that count is reached discards the run. A low pulse covering fewer than `PRESS_SAMPLES` consecutive ticks, and so any pulse under 1 ms, never raises `press_active`.
- R6: A low level held for 20 or more ticks always raises `press_active`. It stays at 1 for as long as the level stays low.
- R7: While the press is active, fewer than `RELEASE_SAMPLES` consecutive high samples followed by a low sample keep `press_active` at 1 and restart the release count.
- R8: `press_active` falls at the clock edge of the `RELEASE_SAMPLES`-th (default 2) consecutive high tick sample.
- R9: After a release, a new press again needs a full run of `PRESS_SAMPLES` consecutive low samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n_raw | input | 1 | Raw button level, low while pressed, asynchronous |
| tick_1ms | input | 1 | One-cycle sample enable, once per millisecond |
| press_active | output | 1 | Qualified press level, high while a press is accepted |

## Verification
The bench sweeps every low-pulse length from one to twenty-two samples, each followed by a release, and compares every sample against a run-count model. An off-by-one press threshold would then show up either as a nine-sample pulse being accepted or as a ten-sample press being missed. Release bounce patterns check that a single high sample does not end the press, which a design that released on the first high sample would fail. Glitches placed between ticks check that a design sampling on every clock would abort a run it should keep. A tick placed two and then three edges after a level change pins the synchroniser depth, so a missing or extra stage shows up as a sample taken one step too early or too late.

// File: rtl/mrst_pkg.sv
// Shared types for the manual reset button qualifier.
package mrst_pkg;

    // Qualifier states; the press output is high in PRESSED and RELEASE_CHECK.
    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_QUALIFY       = 2'd1,
        ST_PRESSED       = 2'd2,
        ST_RELEASE_CHECK = 2'd3
    } mrst_state_e;

endpackage

// File: rtl/mrst_sync.sv
// Flop-chain synchroniser for the raw button level.
// Assumes: the input is asynchronous and idles high, so every stage
// resets to 1 and no false press appears when reset is released.
module mrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the chain, first stage at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

    // R1: the synchronised level is high right after reset.
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> q_sync);

endmodule

// File: rtl/mrst_run_counter.sv
// Counter of consecutive matching samples.
// Assumes: the controller steps it once per matching sample and clears it
// instead of stepping when the run is complete; last flags the final count.
module mrst_run_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Clear has priority; otherwise count one more matching sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

    // R4: the run count never passes its final value.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

    // R4: the controller completes the run instead of stepping past it.
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);

endmodule

// File: rtl/mrst_fsm.sv
// Press/release state machine for the button qualifier.
// Assumes: btn_sync is already synchronised and tick is one cycle wide.
// Both run limits are at least 2.
module mrst_fsm
    import mrst_pkg::*;
#(
    parameter int PRESS_SAMPLES   = 10,
    parameter int RELEASE_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_sync,
    input  logic tick,
    input  logic press_last,
    input  logic rel_last,
    output logic press_clear,
    output logic press_step,
    output logic rel_clear,
    output logic rel_step,
    output logic press_active
);

    mrst_state_e state_q, state_d;
    logic        smp_low, smp_high;

    assign smp_low  = tick & ~btn_sync;
    assign smp_high = tick &  btn_sync;

    // Next state and counter control from the current sample.
    always_comb begin
        state_d     = state_q;
        press_clear = 1'b0;
        press_step  = 1'b0;
        rel_clear   = 1'b0;
        rel_step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (smp_low) begin
                    press_step = 1'b1;
                    state_d    = ST_QUALIFY;
                end
            end
            ST_QUALIFY: begin
                if (smp_low) begin
                    if (press_last) begin
                        press_clear = 1'b1;
                        state_d     = ST_PRESSED;
                    end else begin
                        press_step = 1'b1;
                    end
                end else if (smp_high) begin
                    press_clear = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            ST_PRESSED: begin
                if (smp_high) begin
                    rel_step = 1'b1;
                    state_d  = ST_RELEASE_CHECK;
                end
            end
            ST_RELEASE_CHECK: begin
                if (smp_high) begin
                    if (rel_last) begin
                        rel_clear = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        rel_step = 1'b1;
                    end
                end else if (smp_low) begin
                    rel_clear = 1'b1;
                    state_d   = ST_PRESSED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign press_active = (state_q == ST_PRESSED) || (state_q == ST_RELEASE_CHECK);

    // R3: no state change on a cycle without a tick.
    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    // R4: the press output rises only after a low tick sample.
    assert_rise_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(press_active) |-> $past(smp_low));

    // R5: a high sample during qualification drops the run.
    assert_high_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUALIFY && smp_high) |=> state_q == ST_IDLE);

    // R7: a low sample during release checking returns to the pressed state.
    assert_bounce_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE_CHECK && smp_low) |=> state_q == ST_PRESSED);

    // R8: the press output falls only after a high tick sample.
    assert_fall_on_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(press_active) |-> $past(smp_high));

endmodule

// File: rtl/mrst_qualifier.sv
// Top of the manual reset button qualifier: synchroniser, two run
// counters and the press/release state machine.
// Assumes: the button idles high and tick_1ms pulses for one cycle each ms.
module mrst_qualifier #(
    parameter int SYNC_STAGES     = 2,
    parameter int PRESS_SAMPLES   = 10,
    parameter int RELEASE_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_raw,
    input  logic tick_1ms,
    output logic press_active
);

    logic btn_sync;
    logic press_clear, press_step, press_last;
    logic rel_clear, rel_step, rel_last;

    mrst_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (btn_n_raw),
        .q_sync  (btn_sync)
    );

    mrst_run_counter #(.LIMIT(PRESS_SAMPLES)) press_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (press_clear),
        .step  (press_step),
        .last  (press_last)
    );

    mrst_run_counter #(.LIMIT(RELEASE_SAMPLES)) rel_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rel_clear),
        .step  (rel_step),
        .last  (rel_last)
    );

    mrst_fsm #(
        .PRESS_SAMPLES   (PRESS_SAMPLES),
        .RELEASE_SAMPLES (RELEASE_SAMPLES)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_sync     (btn_sync),
        .tick         (tick_1ms),
        .press_last   (press_last),
        .rel_last     (rel_last),
        .press_clear  (press_clear),
        .press_step   (press_step),
        .rel_clear    (rel_clear),
        .rel_step     (rel_step),
        .press_active (press_active)
    );

    // R1: no press is reported in the cycle after reset.
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !press_active);

endmodule

// File: tb/mrst_qualifier_tb.sv
`timescale 1ns/1ps
module mrst_qualifier_tb_top;

    localparam int PRESS_N = 10;
    localparam int REL_N   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n_raw = 1'b1;
    logic tick_1ms = 1'b0;
    logic press_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Requirement model state.
    bit m_pressed = 1'b0;
    int m_lowrun  = 0;
    int m_highrun = 0;

    always #2 clk = ~clk;

    mrst_qualifier #(
        .SYNC_STAGES     (2),
        .PRESS_SAMPLES   (PRESS_N),
        .RELEASE_SAMPLES (REL_N)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_n_raw    (btn_n_raw),
        .tick_1ms     (tick_1ms),
        .press_active (press_active)
    );

    task automatic check(input logic expv, input string req);
        n_checks++;
        if (press_active !== expv) begin
            n_fail++;
            $display("FAIL %s: press_active=%0b expected=%0b at %0t", req, press_active, expv, $time);
        end
    endtask

    // Apply one sampled level to the requirement model.
    task automatic model(input logic lvl);
        if (!m_pressed) begin
            m_highrun = 0;
            if (!lvl) begin
                m_lowrun++;
                if (m_lowrun == PRESS_N) begin
                    m_pressed = 1'b1;
                    m_lowrun  = 0;
                end
            end else begin
                m_lowrun = 0;
            end
        end else begin
            m_lowrun = 0;
            if (lvl) begin
                m_highrun++;
                if (m_highrun == REL_N) begin
                    m_pressed = 1'b0;
                    m_highrun = 0;
                end
            end else begin
                m_highrun = 0;
            end
        end
    endtask

    // Drive the level, then tick on the gap-th rising edge after it.
    task automatic sample_gap(input logic lvl, input int gap, input logic seen, input string req);
        @(negedge clk);
        btn_n_raw = lvl;
        repeat (gap - 1) @(negedge clk);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        model(seen);
        check(m_pressed, req);
    endtask

    task automatic sample(input logic lvl, input string req);
        sample_gap(lvl, 4, lvl, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 after reset");
        sample(1'b1, "R1 idle sample");

        // R4 R5 R6 R8: sweep low-pulse lengths, each followed by release.
        for (int len = 1; len <= 22; len++) begin
            for (int k = 0; k < len; k++) begin
                sample(1'b0, (len < PRESS_N) ? "R5 short pulse" : (len >= 20 ? "R6 long press" : "R4 press"));
            end
            for (int k = 0; k < 3; k++) sample(1'b1, "R8 release");
        end

        // R7: release bounce keeps the press, then R8 releases on two highs.
        for (int k = 0; k < 12; k++) sample(1'b0, "R4 press for bounce");
        sample(1'b1, "R7 single high");
        sample(1'b0, "R7 bounce back low");
        sample(1'b1, "R7 single high again");
        sample(1'b0, "R7 bounce again");
        sample(1'b1, "R8 first high");
        sample(1'b1, "R8 second high");

        // R9: a new press needs the full run again.
        for (int k = 0; k < PRESS_N; k++) sample(1'b0, "R9 fresh press");
        sample(1'b1, "R8 release a");
        sample(1'b1, "R8 release b");

        // R3: glitches between ticks do not break a low run.
        for (int k = 0; k < PRESS_N - 1; k++) begin
            sample(1'b0, "R3 low run");
            @(negedge clk); btn_n_raw = 1'b1;
            @(negedge clk); btn_n_raw = 1'b0;
        end
        sample(1'b0, "R3 run completes despite glitches");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); btn_n_raw = 1'b1;
            @(negedge clk); btn_n_raw = 1'b0;
            sample(1'b0, "R3 held despite glitches");
        end
        // R3: long low level without any tick changes nothing.
        sample(1'b1, "R8 release c");
        sample(1'b1, "R8 release d");
        @(negedge clk); btn_n_raw = 1'b0;
        repeat (60) @(negedge clk);
        check(1'b0, "R3 no tick no press");
        btn_n_raw = 1'b1;
        repeat (4) @(negedge clk);

        // R2: tick two edges after a change still sees the old level.
        for (int k = 0; k < PRESS_N - 1; k++) sample(1'b0, "R2 prep run");
        sample_gap(1'b1, 2, 1'b0, "R2 old level used");
        sample_gap(1'b1, 3, 1'b1, "R2 new level used");
        sample(1'b1, "R2 release");
        // R2: a third-edge tick sees a fresh high and aborts a run.
        for (int k = 0; k < PRESS_N - 1; k++) sample(1'b0, "R2 prep run b");
        sample_gap(1'b1, 3, 1'b1, "R2 abort seen");
        sample(1'b0, "R5 restart after abort");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule